// File: doc/BRIEF.md
# NAND Boot Image Copier with Bad-Block Skip

This block copies a boot image out of NAND flash into a destination memory with no processor involved. When reset is released it takes a starting flash byte offset and an image length from its configuration inputs. It then asks an external page sequencer for one page at a time. After the sequencer acknowledges, the block reads the page buffer byte by byte and writes the main-area bytes to a destination write port. The bytes go out in order, at a destination position that starts at zero.

On the first two pages it reads in each erase block, the block first inspects the bad-block marker in the spare area. If the block is marked bad, the flash offset jumps to the start of the next erase block and the destination position falls back to the erase-block multiple at or below it. The copy then carries on from there, so good data overwrites whatever that bad block had already contributed. The run ends with a done flag once the image length is covered. It ends with a sticky error flag if the sequencer reports a flash timeout or an uncorrectable ECC error on any page.

Geometry is set by configuration inputs:
- Page-size code: 0 selects 512-byte pages, 1 selects 2048-byte pages, and 2 or 3 select 4096-byte pages.
- Block-size code b: a block holds 2^(b+5) pages.
- Port-width bit: set for a 16-bit flash port.

The page buffer is a synchronous read port. `bufData` must show the byte at the address `bufAddr` held during the previous cycle, by the next rising edge. The main data starts at buffer offset 0 and the spare area starts at buffer offset equal to the page size.

Top module: `nand_boot_copier`

## Requirements
- R1: Once reset is released, the first page requested is `cfgFlashOffs` divided by the page size (512, 2048 or 4096 bytes for codes 0, 1 and 2/3). Each later page request follows the flash offset.
- R2: For every accepted page, all main-area bytes are written to the destination in ascending order, byte j at address (destination position + j). The destination position starts at 0 and grows by one page after each copied page.
- R3: `bootDone` rises once the destination position reaches or passes `cfgImageBytes`, so the last page is always written whole. After that no further page is requested. If the image length is 0, `bootDone` rises without any request.
- R4: The marker byte is at buffer offset pageSize+5 for 512-byte pages and at pageSize+0 for 2048- and 4096-byte pages. A non-0xFF byte at the other of those two spare positions has no effect.
- R5: The marker is inspected only on the first two pages read since the current block was entered. A block is entered at start, on crossing a block boundary, or after a skip. A bad marker on any later page of the block is ignored and that page is copied.
- R6: On an 8-bit port a marker byte other than 0xFF makes the block bad. On a 16-bit port the block is bad only if both the marker byte and the byte after it differ from 0xFF.
- R7: For a bad block, nothing of the offending page is written. The flash offset moves up to the next block boundary and the destination position moves down to a block multiple.
- R8: A block holds 2^(cfgBlkPages+5) pages, and skip rounding uses that block size.
- R9: If `pgTimeoutErr` or `pgEccErr` is high with `pgAck`, `bootError` is set and stays set. No further page request or destination write follows.
- R10: Every acknowledge without an error flag is followed, in the next cycle, by a one-cycle `pgEvtClr` pulse that clears the completion event. An errored acknowledge gets none.
- R11: `pgReq` stays high with `pgNum` unchanged until `pgAck` is seen.
- R12: `bootDone` and `bootError` are never both high. After reset both are low, and neither a request nor a write is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgPageSize | input | 2 | Page size code (0: 512, 1: 2048, 2/3: 4096) |
| cfgBlkPages | input | 2 | Pages per block = 2^(value+5) |
| cfgWidePort | input | 1 | 1 for a 16-bit flash port |
| cfgFlashOffs | input | ADDR_W | Starting flash byte offset |
| cfgImageBytes | input | ADDR_W | Image length in bytes |
| pgReq | output | 1 | Page read request |
| pgNum | output | ADDR_W-9 | Page number of the request |
| pgAck | input | 1 | Page read complete, one cycle |
| pgTimeoutErr | input | 1 | Flash timeout, valid with pgAck |
| pgEccErr | input | 1 | Uncorrectable ECC error, valid with pgAck |
| pgEvtClr | output | 1 | Write-back clear of the completion event |
| bufAddr | output | BUF_AW | Page buffer byte offset |
| bufData | input | 8 | Page buffer byte, one cycle after bufAddr |
| memWe | output | 1 | Destination write strobe |
| memAddr | output | ADDR_W | Destination byte address |
| memData | output | 8 | Destination byte |
| bootDone | output | 1 | Image copied |
| bootError | output | 1 | Boot stopped by a read error |

## Verification
The bench aims at three kinds of marker trap:
- A bad marker on the third page of a block. A design that inspects every page would skip a good block there.
- A decoy byte at the unused spare position. A design with the marker offset swapped would treat it as bad.
- A 16-bit port where only one of the two marker bytes is cleared. A design that uses the 8-bit rule would skip the block.

Skips are placed on the second page of a block and just after a block boundary that the copy crossed on its own. A design that forgets to drop the destination back to the block multiple, or that does not restart its two-page window at the boundary, writes to the wrong addresses or reads the wrong pages. Other runs cover:
- an image length that ends inside a 4096-byte page, to show the last page is copied whole;
- a zero length;
- timeout and ECC errors on the first page and on a later page, to show that no page or write follows.

// File: rtl/nand_boot_pkg.sv
package nand_boot_pkg;

  typedef enum logic [3:0] {
    S_START, S_REQ, S_CLR, S_MK0, S_MK1, S_MK2,
    S_COPY, S_DRAIN, S_ADV, S_DONE, S_ERR
  } bootState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic ldStart;
    logic markLo;
    logic markHi;
    logic skipBlock;
    logic copyIssue;
    logic advance;
  } dpStrobe_t;

endpackage

// File: rtl/nand_boot_datapath.sv
module nand_boot_datapath
  import nand_boot_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int PAGE_W = 15,
  parameter int BUF_AW = 13,
  parameter int SMALL_MARK = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        cfgPageSize,
  input  logic [1:0]        cfgBlkPages,
  input  logic              cfgWidePort,
  input  logic [ADDR_W-1:0] cfgFlashOffs,
  input  logic [ADDR_W-1:0] cfgImageBytes,
  input  dpStrobe_t         st,
  output logic [PAGE_W-1:0] pgNum,
  output logic [BUF_AW-1:0] bufAddr,
  input  logic [7:0]        bufData,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memData,
  output logic              markCheck,
  output logic              isBad,
  output logic              copyLast,
  output logic              imageFull,
  output logic              imageEmpty
);

  logic [4:0]        pgShift, blkShift;
  logic [ADDR_W-1:0] pageBytes, blkBytes, blkMask, offsShift, offsNext;
  logic [ADDR_W-1:0] offs, pos;
  logic [ADDR_W:0]   posEnd;
  logic [BUF_AW-1:0] markBase, byteCnt, idxQ;
  logic [1:0]        inBlk;
  logic [7:0]        mark0;
  logic              pend;

  always_comb begin
    case (cfgPageSize)
      2'd0:    pgShift = 5'd9;
      2'd1:    pgShift = 5'd11;
      default: pgShift = 5'd12;
    endcase
  end

  assign blkShift  = pgShift + 5'd5 + {3'b000, cfgBlkPages};
  assign pageBytes = {{(ADDR_W-1){1'b0}}, 1'b1} << pgShift;
  assign blkBytes  = {{(ADDR_W-1){1'b0}}, 1'b1} << blkShift;
  assign blkMask   = blkBytes - 1'b1;
  assign markBase  = pageBytes[BUF_AW-1:0] +
                     ((cfgPageSize == 2'd0) ? BUF_AW'(SMALL_MARK) : '0);
  assign offsShift = offs >> pgShift;
  assign pgNum     = offsShift[PAGE_W-1:0];
  assign offsNext  = offs + pageBytes;
  assign posEnd    = {1'b0, pos} + {1'b0, pageBytes};

  assign markCheck  = (inBlk < 2'd2);
  assign isBad      = cfgWidePort ? ((mark0 != 8'hFF) && (bufData != 8'hFF))
                                  : (mark0 != 8'hFF);
  assign copyLast   = (byteCnt == pageBytes[BUF_AW-1:0] - 1'b1);
  assign imageFull  = (posEnd >= {1'b0, cfgImageBytes});
  assign imageEmpty = (cfgImageBytes == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      offs    <= '0;
      pos     <= '0;
      inBlk   <= '0;
      byteCnt <= '0;
      idxQ    <= '0;
      bufAddr <= '0;
      mark0   <= 8'hFF;
      pend    <= 1'b0;
      memWe   <= 1'b0;
      memAddr <= '0;
      memData <= '0;
    end else begin
      pend  <= st.copyIssue;
      memWe <= pend;
      if (pend) begin
        memData <= bufData;
        memAddr <= pos + ADDR_W'(idxQ);
      end
      if (st.ldStart) begin
        offs    <= cfgFlashOffs;
        pos     <= '0;
        inBlk   <= '0;
        byteCnt <= '0;
      end
      if (st.markLo) bufAddr <= markBase;
      if (st.markHi) begin
        bufAddr <= markBase + 1'b1;
        mark0   <= bufData;
      end
      if (st.copyIssue) begin
        bufAddr <= byteCnt;
        idxQ    <= byteCnt;
        byteCnt <= byteCnt + 1'b1;
      end
      if (st.skipBlock) begin
        offs  <= (offs + blkBytes) & ~blkMask;
        pos   <= pos & ~blkMask;
        inBlk <= '0;
      end
      if (st.advance) begin
        offs    <= offsNext;
        pos     <= posEnd[ADDR_W-1:0];
        byteCnt <= '0;
        if ((offsNext & blkMask) == '0) inBlk <= '0;
        else if (inBlk != 2'd2)         inBlk <= inBlk + 2'd1;
      end
    end
  end

  // R7
  skip_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.skipBlock |=> (((pos & blkMask) == '0) && ((offs & blkMask) == '0)));

  // R5
  mark_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.markLo |-> (inBlk < 2'd2));

endmodule

// File: rtl/nand_boot_ctrl.sv
module nand_boot_ctrl
  import nand_boot_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      pgAck,
  input  logic      pgTimeoutErr,
  input  logic      pgEccErr,
  input  logic      markCheck,
  input  logic      isBad,
  input  logic      copyLast,
  input  logic      imageFull,
  input  logic      imageEmpty,
  output dpStrobe_t st,
  output logic      pgReq,
  output logic      pgEvtClr,
  output logic      bootDone,
  output logic      bootError
);

  bootState_t state, stateNext;

  always_comb begin
    stateNext = state;
    st        = '0;
    case (state)
      S_START: begin
        st.ldStart = 1'b1;
        stateNext  = imageEmpty ? S_DONE : S_REQ;
      end
      S_REQ:
        if (pgAck) stateNext = (pgTimeoutErr || pgEccErr) ? S_ERR : S_CLR;
      S_CLR:
        stateNext = markCheck ? S_MK0 : S_COPY;
      S_MK0: begin
        st.markLo = 1'b1;
        stateNext = S_MK1;
      end
      S_MK1: begin
        st.markHi = 1'b1;
        stateNext = S_MK2;
      end
      S_MK2:
        if (isBad) begin
          st.skipBlock = 1'b1;
          stateNext    = S_REQ;
        end else begin
          stateNext = S_COPY;
        end
      S_COPY: begin
        st.copyIssue = 1'b1;
        if (copyLast) stateNext = S_DRAIN;
      end
      S_DRAIN:
        stateNext = S_ADV;
      S_ADV: begin
        st.advance = 1'b1;
        stateNext  = imageFull ? S_DONE : S_REQ;
      end
      default: stateNext = state;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_START;
    else       state <= stateNext;
  end

  assign pgReq     = (state == S_REQ);
  assign pgEvtClr  = (state == S_CLR);
  assign bootDone  = (state == S_DONE);
  assign bootError = (state == S_ERR);

  // R12
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(bootDone && bootError));

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    bootError |=> (bootError && !pgReq));

  // R9
  err_on_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pgReq && pgAck && (pgTimeoutErr || pgEccErr)) |=> bootError);

  // R3
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    bootDone |=> (bootDone && !pgReq));

  // R10
  clr_after_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pgReq && pgAck && !pgTimeoutErr && !pgEccErr) |=> pgEvtClr);

endmodule

// File: rtl/nand_boot_copier.sv
module nand_boot_copier
  import nand_boot_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int BUF_AW = 13,
  localparam int PAGE_W = ADDR_W - 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        cfgPageSize,
  input  logic [1:0]        cfgBlkPages,
  input  logic              cfgWidePort,
  input  logic [ADDR_W-1:0] cfgFlashOffs,
  input  logic [ADDR_W-1:0] cfgImageBytes,
  output logic              pgReq,
  output logic [PAGE_W-1:0] pgNum,
  input  logic              pgAck,
  input  logic              pgTimeoutErr,
  input  logic              pgEccErr,
  output logic              pgEvtClr,
  output logic [BUF_AW-1:0] bufAddr,
  input  logic [7:0]        bufData,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memData,
  output logic              bootDone,
  output logic              bootError
);

  dpStrobe_t st;
  logic markCheck, isBad, copyLast, imageFull, imageEmpty;

  nand_boot_ctrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .pgAck(pgAck), .pgTimeoutErr(pgTimeoutErr), .pgEccErr(pgEccErr),
    .markCheck(markCheck), .isBad(isBad), .copyLast(copyLast),
    .imageFull(imageFull), .imageEmpty(imageEmpty),
    .st(st), .pgReq(pgReq), .pgEvtClr(pgEvtClr),
    .bootDone(bootDone), .bootError(bootError)
  );

  nand_boot_datapath #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .BUF_AW(BUF_AW)
  ) dp_i (
    .clk(clk), .rstN(rstN),
    .cfgPageSize(cfgPageSize), .cfgBlkPages(cfgBlkPages),
    .cfgWidePort(cfgWidePort), .cfgFlashOffs(cfgFlashOffs),
    .cfgImageBytes(cfgImageBytes), .st(st),
    .pgNum(pgNum), .bufAddr(bufAddr), .bufData(bufData),
    .memWe(memWe), .memAddr(memAddr), .memData(memData),
    .markCheck(markCheck), .isBad(isBad), .copyLast(copyLast),
    .imageFull(imageFull), .imageEmpty(imageEmpty)
  );

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pgReq && !pgAck) |=> (pgReq && $stable(pgNum)));

  // R2
  no_write_during_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    pgReq |-> !memWe);

endmodule

// File: tb/nand_boot_copier_tb_top.sv
module nand_boot_copier_tb_top;
  localparam int ADDR_W = 24;
  localparam int BUF_AW = 13;
  localparam int PAGE_W = ADDR_W - 9;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] cfgPageSize = '0, cfgBlkPages = '0;
  logic cfgWidePort = 1'b0;
  logic [ADDR_W-1:0] cfgFlashOffs = '0, cfgImageBytes = '0;
  logic pgReq, pgEvtClr, memWe, bootDone, bootError;
  logic [PAGE_W-1:0] pgNum;
  logic pgAck = 1'b0, pgTimeoutErr = 1'b0, pgEccErr = 1'b0;
  logic [BUF_AW-1:0] bufAddr;
  logic [7:0] bufData = 8'hFF;
  logic [ADDR_W-1:0] memAddr;
  logic [7:0] memData;

  always #4 clk = ~clk;

  nand_boot_copier #(.ADDR_W(ADDR_W), .BUF_AW(BUF_AW)) dut_i (
    .clk(clk), .rstN(rstN),
    .cfgPageSize(cfgPageSize), .cfgBlkPages(cfgBlkPages),
    .cfgWidePort(cfgWidePort), .cfgFlashOffs(cfgFlashOffs),
    .cfgImageBytes(cfgImageBytes),
    .pgReq(pgReq), .pgNum(pgNum), .pgAck(pgAck),
    .pgTimeoutErr(pgTimeoutErr), .pgEccErr(pgEccErr), .pgEvtClr(pgEvtClr),
    .bufAddr(bufAddr), .bufData(bufData),
    .memWe(memWe), .memAddr(memAddr), .memData(memData),
    .bootDone(bootDone), .bootError(bootError)
  );

  int nChecks = 0, nFails = 0;
  int ps = 512, mk = 5, errAt = -1, errMode = 0;
  int reqIdx = 0, clrCnt = 0, curPage = 0, lat = 0;
  bit wideNow = 0;
  bit badLo[int], badHi[int], decoy[int];
  int expPages[$], expWrA[$], expWrD[$];

  task automatic chk(bit ok, string tag, longint act, longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int dataByte(int pg, int j);
    return ((pg * 13) + (j * 3) + (j >> 8)) & 255;
  endfunction

  function automatic int flashByte(int pg, int a);
    int k;
    if (a < ps) return dataByte(pg, a);
    k = a - ps;
    if (k == mk && badLo.exists(pg)) return 0;
    if (k == mk + 1 && badHi.exists(pg)) return 8'h3C;
    if (k == ((mk == 5) ? 0 : 5) && decoy.exists(pg)) return 0;
    return 255;
  endfunction

  function automatic bit pageBad(int pg);
    if (wideNow) return badLo.exists(pg) && badHi.exists(pg);
    return badLo.exists(pg);
  endfunction

  // single bench process on the falling edge: responder, buffer, monitors
  always @(negedge clk) begin
    if (!rstN) begin
      pgAck = 1'b0; pgTimeoutErr = 1'b0; pgEccErr = 1'b0; lat = 0;
    end else begin
      if (pgEvtClr) clrCnt++;
      if (memWe) begin
        if (expWrA.size() == 0) chk(0, "R2 unexpected write", memAddr, -1);
        else begin
          int ea, ed;
          ea = expWrA.pop_front(); ed = expWrD.pop_front();
          chk(memAddr == ea, "R2/R7 write address", memAddr, ea);
          chk(memData == ed, "R2 write data", memData, ed);
        end
      end
      if (pgAck) begin
        pgAck = 1'b0; pgTimeoutErr = 1'b0; pgEccErr = 1'b0;
      end else if (pgReq) begin
        lat++;
        if (lat == 3) begin
          lat = 0;
          pgAck = 1'b1;
          curPage = int'(pgNum);
          pgTimeoutErr = (reqIdx == errAt) && (errMode == 1);
          pgEccErr     = (reqIdx == errAt) && (errMode == 2);
          if (expPages.size() == 0) chk(0, "R1 unexpected page request", pgNum, -1);
          else begin
            int ep;
            ep = expPages.pop_front();
            chk(int'(pgNum) == ep, "R1/R7 page number", pgNum, ep);
          end
          reqIdx++;
        end
      end else lat = 0;
    end
    bufData = 8'(flashByte(curPage, int'(bufAddr)));
  end

  task automatic runTest(string name, int pgSel, int blkSel, bit wide,
                         int start, int size, int eAt, int eMode);
    int blk, pos, offs, n, i, pg, cyc, nPg;
    bit expErr;
    rstN = 1'b0;
    cfgPageSize = 2'(pgSel); cfgBlkPages = 2'(blkSel); cfgWidePort = wide;
    cfgFlashOffs = ADDR_W'(start); cfgImageBytes = ADDR_W'(size);
    ps = (pgSel == 0) ? 512 : (pgSel == 1) ? 2048 : 4096;
    mk = (ps == 512) ? 5 : 0;
    blk = ps << (blkSel + 5);
    wideNow = wide; errAt = eAt; errMode = eMode;
    expPages.delete(); expWrA.delete(); expWrD.delete();
    // behavioural model of the boot copy
    pos = 0; offs = start; n = 0; expErr = 0;
    while (pos < size) begin
      i = 0;
      while (1) begin
        pg = offs / ps;
        expPages.push_back(pg);
        if (n == errAt) begin expErr = 1; break; end
        n++;
        if (i < 2 && pageBad(pg)) begin
          offs = (offs + blk) & ~(blk - 1);
          pos  = pos & ~(blk - 1);
          break;
        end
        i++;
        for (int j = 0; j < ps; j++) begin
          expWrA.push_back(pos + j);
          expWrD.push_back(dataByte(pg, j));
        end
        pos += ps; offs += ps;
        if ((offs % blk) == 0 || pos >= size) break;
      end
      if (expErr) break;
    end
    nPg = expPages.size();
    repeat (3) @(negedge clk);
    reqIdx = 0; clrCnt = 0;
    // R12 reset state
    chk(!bootDone && !bootError && !memWe && !pgReq, {"R12 reset state ", name},
        {bootDone, bootError, memWe, pgReq}, 0);
    rstN = 1'b1;
    cyc = 0;
    while (!(bootDone || bootError) && cyc < 60000) begin
      @(negedge clk);
      cyc++;
    end
    repeat (12) @(negedge clk);
    chk(cyc < 60000, {"R3 run finished ", name}, cyc, 60000);
    chk(bootDone == !expErr, {"R3 done flag ", name}, bootDone, !expErr);
    chk(bootError == expErr, {"R9 error flag ", name}, bootError, expErr);
    chk(!(bootDone && bootError), {"R12 flags exclusive ", name}, bootDone & bootError, 0);
    chk(expWrA.size() == 0, {"R2 writes missing ", name}, expWrA.size(), 0);
    chk(reqIdx == nPg, {"R1 page request count ", name}, reqIdx, nPg);
    chk(clrCnt == (expErr ? reqIdx - 1 : reqIdx), {"R10 event clears ", name},
        clrCnt, expErr ? reqIdx - 1 : reqIdx);
  endtask

  task automatic finishRun;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin
    // R1 R4 R5: mid-block start, bad marker on third page ignored, decoy byte ignored
    badLo.delete(); badHi.delete(); decoy.delete();
    badLo[5] = 1; decoy[3] = 1;
    runTest("T1", 0, 0, 0, 3 * 512, 1536, -1, 0);
    // R7 R4: first page of block bad on 512-byte device
    badLo.delete(); decoy.delete();
    badLo[0] = 1;
    runTest("T2", 0, 0, 0, 0, 1024, -1, 0);
    // R7 R8: second page bad, 64-page blocks, destination falls back
    badLo.delete();
    badLo[65] = 1;
    runTest("T3", 0, 1, 0, 64 * 512, 1024, -1, 0);
    // R6: 16-bit port, single marker byte not enough, both bytes bad skips
    badLo.delete(); badHi.delete();
    badLo[0] = 1; badLo[1] = 1; badHi[1] = 1;
    runTest("T4", 1, 0, 1, 0, 4096, -1, 0);
    // R6: 8-bit port on large page, marker byte 0 bad
    badLo.delete(); badHi.delete();
    badLo[0] = 1;
    runTest("T5", 1, 0, 0, 0, 2048, -1, 0);
    // R3: 4096-byte pages, image ends mid-page, last page whole
    badLo.delete();
    runTest("T6", 2, 0, 0, 2 * 4096, 5000, -1, 0);
    // R5 R7: window restarts at a crossed block boundary
    badLo[33] = 1;
    runTest("T7", 0, 0, 0, 30 * 512, 2048, -1, 0);
    // R9: timeout on second request
    badLo.delete();
    runTest("T8", 0, 0, 0, 0, 2048, 1, 1);
    // R9: ECC error on first request
    runTest("T9", 0, 0, 0, 0, 2048, 0, 2);
    // R3: zero length
    runTest("T10", 0, 0, 0, 0, 0, -1, 0);
    finishRun();
  end

endmodule